// File: doc/BRIEF.md
# Dynamic Memory Power-Up and CAS-Before-RAS Refresh Controller

This block takes a dynamic memory from power-up to a usable state and then keeps its contents alive. After reset it holds both strobes inactive for a long settling pause. It then runs a fixed number of warm-up cycles, and each of these is itself a CAS-before-RAS refresh. When the warm-up is done it raises a ready flag. From then on an interval timer marks every moment at which a refresh is owed. The memory's own row counter picks the row, so the block drives no address.

Once the memory is ready, the block shares the strobes with an access sequencer through a request/grant pair. The block raises `refReq` while it owes a refresh. It starts a cycle only after it sees `refGrant` high in its idle state, so an access that is already running is never cut short. If the grant comes late, the owed refreshes are counted up to a parameterised limit. They are then issued back to back in one ownership period, and `refReq` drops after the last one. Every time value is a parameter in clock cycles.

Top module: `refresh_ctrl`

## Requirements
- R1: While reset is asserted and on release, `rasN`, `casN`, `weN` and `oeN` are high (1), and `memReady` and `refReq` are low (0).
- R2: For the first `PAUSE_CYC` clock cycles after reset, `rasN` and `casN` both stay high.
- R3: After the pause, exactly `INIT_CYCLES` RAS pulses are issued with no grant needed. `memReady` rises only after the last of them, then stays high. `refReq` is never high while `memReady` is low.
- R4: Every falling edge of `rasN` happens while `casN` is low, and `casN` has been low for exactly `T_CSU` cycles before it. `casN` never falls while `rasN` is low.
- R5: `casN` stays low for exactly `T_CHOLD` cycles after `rasN` falls, and each `rasN` low pulse lasts exactly `T_RAS` cycles.
- R6: Between two `rasN` low pulses, `rasN` is high for at least `T_RP` cycles.
- R7: `weN` and `oeN` are high in every cycle, because no refresh cycle moves data.
- R8: A refresh becomes owed every `INTERVAL_CYC` cycles, counted from the cycle in which `memReady` rises. `refReq` rises `INTERVAL_CYC` cycles after `memReady` rises, and again every `INTERVAL_CYC` cycles after that when each grant is prompt.
- R9: After `memReady`, no RAS pulse is started while `refGrant` is low. A high `refGrant` while no refresh is owed has no effect: there is no strobe activity and `refReq` stays low.
- R10: While the grant is withheld, owed refreshes accumulate up to `MAX_PEND`. When the grant arrives, exactly that many RAS pulses run back to back, and then `refReq` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refGrant | input | 1 | Strobe ownership granted by the access sequencer |
| refReq | output | 1 | Refresh owed or in progress; strobes are owned by this block while granted |
| memReady | output | 1 | Power-up sequence complete; memory may be accessed |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, held high |
| oeN | output | 1 | Output enable, held high |

## Verification
Each state of the sequencer drives the strobes directly. A wrong phase count or a wrong state therefore shows one cycle later as a strobe pulse of the wrong width, or as RAS falling without CAS already low. The bench measures every edge of each pulse. A corrupted pending count or interval counter shows at the next refresh boundary. It appears as a `refReq` rise at the wrong cycle, or as the wrong number of pulses in a burst. This is at most one interval after the fault. A fault in the warm-up count shows when `memReady` rises after the wrong number of pulses.

// File: rtl/refresh_ctrl_pkg.sv
package refresh_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_CSETUP,
    ST_RASACT,
    ST_PRECH
  } refState_e;

  typedef struct packed {
    logic phaseClr;
    logic takeInit;
    logic takePend;
    logic setReady;
    logic rasLow;
    logic casLow;
  } refStrobe_t;

endpackage

// File: rtl/refresh_dp.sv
module refresh_dp
  import refresh_ctrl_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_CYCLES  = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_PEND     = 4,
  parameter int PH_W         = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  refStrobe_t      strobe,
  output logic            pauseDone,
  output logic            initDone,
  output logic            pendAny,
  output logic [PH_W-1:0] phase,
  output logic            memReady,
  output logic            rasN,
  output logic            casN
);

  localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);
  localparam int INIT_W  = $clog2(INIT_CYCLES + 1);
  localparam int IV_W    = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam int PEND_W  = $clog2(MAX_PEND + 1);

  logic [PAUSE_W-1:0] pauseCnt;
  logic [INIT_W-1:0]  initCnt;
  logic [IV_W-1:0]    ivCnt;
  logic [PEND_W-1:0]  pendCnt;
  logic               ivTick;

  assign pauseDone = (pauseCnt == PAUSE_W'(PAUSE_CYC));
  assign initDone  = (initCnt == INIT_W'(INIT_CYCLES));
  assign pendAny   = (pendCnt != '0);
  assign ivTick    = memReady && (ivCnt == IV_W'(INTERVAL_CYC - 1));

  // power-up settling pause
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pauseCnt <= '0;
    else if (!pauseDone) pauseCnt <= pauseCnt + 1'b1;
  end

  // phase counter shared by all timed states
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phase <= '0;
    else if (strobe.phaseClr) phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  // warm-up cycle count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                initCnt <= '0;
    else if (strobe.takeInit) initCnt <= initCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) memReady <= 1'b0;
    else       memReady <= memReady | strobe.setReady;
  end

  // refresh interval timer, free running once ready
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ivCnt <= '0;
    else if (ivTick)   ivCnt <= '0;
    else if (memReady) ivCnt <= ivCnt + 1'b1;
  end

  // owed refresh count, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendCnt <= '0;
    else begin
      unique case ({ivTick, strobe.takePend})
        2'b10: if (pendCnt != PEND_W'(MAX_PEND)) pendCnt <= pendCnt + 1'b1;
        2'b01: pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  // registered strobe pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasN <= 1'b1;
      casN <= 1'b1;
    end else begin
      rasN <= !strobe.rasLow;
      casN <= !strobe.casLow;
    end
  end

  p_take_has_pend_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takePend |-> pendCnt != '0)
    else $error("refresh taken with nothing owed");

  p_ready_after_init_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReady) |-> initCnt == INIT_W'(INIT_CYCLES))
    else $error("ready before warm-up finished");

  p_cbr_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> !casN)
    else $error("RAS fell without CAS low");

  p_cas_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> rasN)
    else $error("CAS fell while RAS low");

endmodule

// File: rtl/refresh_fsm.sv
module refresh_fsm
  import refresh_ctrl_pkg::*;
#(
  parameter int T_CSU   = 1,
  parameter int T_CHOLD = 1,
  parameter int T_RAS   = 6,
  parameter int T_RP    = 4,
  parameter int PH_W    = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            refGrant,
  input  logic            pauseDone,
  input  logic            initDone,
  input  logic            pendAny,
  input  logic [PH_W-1:0] phase,
  input  logic            memReady,
  output refStrobe_t      strobe,
  output logic            refReq
);

  refState_e st, stNext;
  logic csuEnd, rasEnd, rpEnd;

  assign csuEnd = (phase == PH_W'(T_CSU - 1));
  assign rasEnd = (phase == PH_W'(T_RAS - 1));
  assign rpEnd  = (phase == PH_W'(T_RP - 1));

  always_comb begin
    stNext          = st;
    strobe          = '0;
    strobe.rasLow   = (st == ST_RASACT);
    strobe.casLow   = (st == ST_CSETUP) ||
                      ((st == ST_RASACT) && (phase < PH_W'(T_CHOLD)));
    unique case (st)
      ST_PAUSE:  if (pauseDone) stNext = ST_CSETUP;
      ST_IDLE:   if (pendAny && refGrant) stNext = ST_CSETUP;
      ST_CSETUP: if (csuEnd) begin
                   stNext          = ST_RASACT;
                   strobe.takeInit = !memReady;
                   strobe.takePend = memReady;
                 end
      ST_RASACT: if (rasEnd) stNext = ST_PRECH;
      ST_PRECH:  if (rpEnd) begin
                   if (!memReady) begin
                     if (initDone) begin
                       stNext          = ST_IDLE;
                       strobe.setReady = 1'b1;
                     end else begin
                       stNext = ST_CSETUP;
                     end
                   end else begin
                     stNext = pendAny ? ST_CSETUP : ST_IDLE;
                   end
                 end
      default:   stNext = ST_IDLE;
    endcase
    strobe.phaseClr = (stNext != st);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_PAUSE;
    else       st <= stNext;
  end

  assign refReq = memReady && (pendAny || (st != ST_IDLE));

  p_grant_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && !refGrant) |=> (st == ST_IDLE))
    else $error("refresh started without grant");

endmodule

// File: rtl/refresh_ctrl.sv
module refresh_ctrl
  import refresh_ctrl_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_CYCLES  = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int MAX_PEND     = 4,
  parameter int T_CSU        = 1,
  parameter int T_CHOLD      = 1,
  parameter int T_RAS        = 6,
  parameter int T_RP         = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  output logic refReq,
  output logic memReady,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic oeN
);

  localparam int PH_MAX0 = (T_CSU > T_RAS) ? T_CSU : T_RAS;
  localparam int PH_MAX  = (PH_MAX0 > T_RP) ? PH_MAX0 : T_RP;
  localparam int PH_W    = $clog2(PH_MAX + 1);

  refStrobe_t      strobe;
  logic            pauseDone, initDone, pendAny;
  logic [PH_W-1:0] phase;

  refresh_fsm #(
    .T_CSU(T_CSU), .T_CHOLD(T_CHOLD), .T_RAS(T_RAS), .T_RP(T_RP), .PH_W(PH_W)
  ) uFsm (
    .clk(clk), .rstN(rstN), .refGrant(refGrant),
    .pauseDone(pauseDone), .initDone(initDone), .pendAny(pendAny),
    .phase(phase), .memReady(memReady), .strobe(strobe), .refReq(refReq)
  );

  refresh_dp #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_CYCLES(INIT_CYCLES),
    .INTERVAL_CYC(INTERVAL_CYC), .MAX_PEND(MAX_PEND), .PH_W(PH_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pauseDone(pauseDone), .initDone(initDone), .pendAny(pendAny),
    .phase(phase), .memReady(memReady), .rasN(rasN), .casN(casN)
  );

  assign weN = 1'b1;
  assign oeN = 1'b1;

  p_pause_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !pauseDone |-> (rasN && casN))
    else $error("strobe active during power-up pause");

endmodule

// File: tb/refresh_ctrl_test.sv
`timescale 1ns/1ps
module refresh_ctrl_test;

  localparam int PAUSE   = 60;
  localparam int INITN   = 8;
  localparam int IVL     = 100;
  localparam int MAXP    = 4;
  localparam int TCSU    = 2;
  localparam int THOLD   = 3;
  localparam int TRAS    = 5;
  localparam int TRP     = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant;
  logic refReq, memReady, rasN, casN, weN, oeN;
  logic autoMode = 1'b0, autoG = 1'b0, manualG = 1'b0;

  int testsRun = 0, testsFailed = 0;
  bit done = 1'b0;

  int rasFalls = 0, cyc = 0;
  int casLowRun = 0, rasLowRun = 0, rasHighRun = 0;
  int pauseBad = 0, weOeBad = 0, earlyReqBad = 0;
  logic prevRas = 1'b1, prevCas = 1'b1;

  always #5 clk = ~clk;

  assign refGrant = autoMode ? autoG : manualG;

  refresh_ctrl #(
    .PAUSE_CYC(PAUSE), .INIT_CYCLES(INITN), .INTERVAL_CYC(IVL),
    .MAX_PEND(MAXP), .T_CSU(TCSU), .T_CHOLD(THOLD), .T_RAS(TRAS), .T_RP(TRP)
  ) uut (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq),
    .memReady(memReady), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  always @(negedge clk) autoG <= refReq;

  // strobe timing monitor
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (cyc <= PAUSE && (!rasN || !casN)) pauseBad++;
      if (!weN || !oeN) weOeBad++;
      if (!memReady && refReq) earlyReqBad++;
      if (prevRas && !rasN) begin
        rasFalls++;
        check(!casN && casLowRun == TCSU, "R4 CAS setup before RAS fall", casLowRun, TCSU);
        check(rasHighRun >= TRP, "R6 RAS precharge", rasHighRun, TRP);
      end
      if (!prevRas && rasN)
        check(rasLowRun == TRAS, "R5 RAS low width", rasLowRun, TRAS);
      if (prevCas && !casN)
        check(rasN, "R4 CAS fall with RAS high", int'(rasN), 1);
      if (!prevCas && casN)
        check(casLowRun == TCSU + THOLD, "R5 CAS hold after RAS fall",
              casLowRun, TCSU + THOLD);
      casLowRun  = casN ? 0 : casLowRun + 1;
      rasLowRun  = rasN ? 0 : rasLowRun + 1;
      rasHighRun = rasN ? rasHighRun + 1 : 0;
      prevRas = rasN;
      prevCas = casN;
    end
  end

  task automatic testReset();
    step();
    check(rasN && casN && weN && oeN, "R1 strobes high in reset",
          {rasN, casN, weN, oeN}, 4'hF);
    check(!memReady && !refReq, "R1 ready/req low in reset", {memReady, refReq}, 0);
    rstN = 1'b1;
    step();
    check(rasN && casN && !memReady && !refReq, "R1 state after release",
          {rasN, casN, memReady, refReq}, 4'b1100);
  endtask

  task automatic testPowerUp();
    int n = 0;
    while (!memReady && n < 5000) begin step(); n++; end
    check(memReady, "R3 ready reached", int'(memReady), 1);
    check(rasFalls == INITN, "R3 warm-up pulse count", rasFalls, INITN);
    check(pauseBad == 0, "R2 strobes quiet in pause", pauseBad, 0);
    check(earlyReqBad == 0, "R3 no request before ready", earlyReqBad, 0);
  endtask

  task automatic testPeriodic();
    int n = 0, f0;
    while (!refReq && n < 1000) begin step(); n++; end
    check(n == IVL, "R8 first request after ready", n, IVL);
    f0 = rasFalls;
    check(f0 == INITN, "R9 no pulse before grant", f0, INITN);
    autoMode = 1'b1;
    while (refReq) step();
    check(rasFalls == f0 + 1, "R8 one pulse per interval", rasFalls - f0, 1);
    n = 0;
    while (!refReq && n < 1000) begin step(); n++; end
    while (refReq) step();
    check(rasFalls == f0 + 2, "R8 second interval pulse", rasFalls - f0, 2);
  endtask

  task automatic testIdleGrant();
    int f0 = rasFalls, reqSeen = 0;
    autoMode = 1'b0;
    manualG = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step();
      if (refReq) reqSeen++;
    end
    manualG = 1'b0;
    check(rasFalls == f0, "R9 idle grant ignored (pulses)", rasFalls - f0, 0);
    check(reqSeen == 0, "R9 idle grant ignored (request)", reqSeen, 0);
  endtask

  task automatic testBacklog();
    int n = 0, f0;
    while (!refReq && n < 1000) begin step(); n++; end
    f0 = rasFalls;
    for (int i = 0; i < 450; i++) step();
    check(rasFalls == f0, "R9 no pulse while grant withheld", rasFalls - f0, 0);
    check(refReq, "R10 request held while owed", int'(refReq), 1);
    manualG = 1'b1;
    n = 0;
    while (refReq && n < 200) begin step(); n++; end
    manualG = 1'b0;
    check(!refReq, "R10 request drops after burst", int'(refReq), 0);
    check(rasFalls - f0 == MAXP, "R10 saturated burst length", rasFalls - f0, MAXP);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    testReset();
    testPowerUp();
    testPeriodic();
    testIdleGrant();
    testBacklog();
    for (int i = 0; i < 5; i++) step();
    check(weOeBad == 0, "R7 WE and OE held high", weOeBad, 0);
    check(memReady, "R3 ready stays high", int'(memReady), 1);
    finish();
  end

endmodule